// File: doc/BRIEF.md
# Two-Clock Frequency Race Comparator

This block decides which of two clocks runs faster. A reference clock and a feedback clock, asynchronous to each other, each drive a counter. Both counters are released from zero at the same moment. The first one to reach a hit threshold marks its clock as the faster one. Once the reference counter passes a larger restart threshold, both counters are cleared and the next race begins. A frequency-search loop around this block can then step an oscillator setting up or down after each race.

All decisions are made in the reference domain. Each hit comparison is registered. The feedback hit flag reaches the reference domain through a synchronizer chain. The reference hit flag is delayed by a chain of the same depth, so neither side gains from the crossing. The exclusive-OR of the two aligned flags rises when exactly one side has hit, and the winner is taken from that rising edge. The clear command to the feedback counter crosses the other way, and the feedback side sends back an acknowledge.

The reference controller is a three-state machine:
- `ST_CLEAR` holds the clear request until the acknowledge arrives.
- `ST_ALIGN` waits as many cycles as the synchronizer is deep, so the reference counter starts together with the feedback counter.
- `ST_RACE` counts and captures the winner.

The transitions are:
- reset → `ST_CLEAR`
- `ST_CLEAR` → `ST_ALIGN` when the acknowledge is seen (the clear request drops on this edge)
- `ST_ALIGN` → `ST_RACE` after `SYNC_STAGES` cycles
- `ST_RACE` → `ST_CLEAR` when the reference count exceeds the restart threshold and the acknowledge is low (the done pulse is issued on this edge)

Top module: `freq_race_cmp`

## Requirements
- R1: While reset is asserted, and after its release until the first race has finished, `race_done` is 0 and `fb_won` is 0.
- R2: Both counters are `CNT_W` bits wide (default 10). The hit threshold defaults to 230, the restart threshold to 240 and the synchronizer depth to 2. Both counters start each race from zero on the same reference edge when the two clocks are identical.
- R3: When the feedback counter reaches the hit threshold first, `fb_won` is 1 when `race_done` pulses.
- R4: When the reference counter reaches the hit threshold first, `fb_won` is 0 when `race_done` pulses.
- R5: A tie, in which both aligned hit flags rise in the same reference cycle, resolves as a reference win (`fb_won` = 0). Identical clocks always produce a tie.
- R6: `race_done` is a single reference-cycle pulse. `fb_won` changes only in a cycle where `race_done` is 1, and holds its value until the next pulse.
- R7: With identical clocks, consecutive `race_done` pulses are exactly 3*SYNC_STAGES + RESTART_AT + 4 reference cycles apart.
- R8: The clear request stays asserted until the feedback side acknowledges it. While the feedback side sees the clear, its counter and hit flag are held at zero.
- R9: The restart threshold must be at least the hit threshold plus SYNC_STAGES + 2. Elaboration stops otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all results are in this domain |
| fb_clk | input | 1 | Feedback clock being compared |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| fb_won | output | 1 | 1 = feedback clock won the last race, 0 = reference won or tie |
| race_done | output | 1 | One-cycle strobe marking a finished race; `fb_won` is valid with it |

## Verification
A race result appears on the reference edge where the count first exceeds RESTART_AT. That is SYNC_STAGES + RESTART_AT + 2 cycles after the align phase starts. `fb_won` is due in the same cycle as the pulse. The bench waits for each pulse and samples on the falling edge, then samples one falling edge later to confirm that the strobe has dropped and the flag has held. For identical clocks, the cycles between pulses are counted and compared with the arithmetic period 3*SYNC_STAGES + RESTART_AT + 4. Feedback periods are swept well away from the reference period on both sides, so that the synchronizer latency cannot change the expected winner.

// File: rtl/freq_race_pkg.sv
package freq_race_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_ALIGN = 2'd1,
        ST_RACE  = 2'd2
    } race_state_t;

endpackage

// File: rtl/race_sync.sv
module race_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= STAGES'({pipe_q, d});
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/race_fb_side.sv
module race_fb_side #(
    parameter int CNT_W  = 10,
    parameter int HIT_AT = 230
) (
    input  logic fb_clk,
    input  logic rst_n,
    input  logic clr_s,
    output logic fb_hit,
    output logic fb_ack
);
    localparam logic [CNT_W-1:0] HIT_V = CNT_W'(HIT_AT);

    logic [CNT_W-1:0] fb_cnt;

    always_ff @(posedge fb_clk or negedge rst_n) begin
        if (!rst_n) begin
            fb_cnt <= '0;
            fb_hit <= 1'b0;
            fb_ack <= 1'b0;
        end else begin
            fb_ack <= clr_s;
            if (clr_s) begin
                fb_cnt <= '0;
                fb_hit <= 1'b0;
            end else begin
                if (fb_cnt != '1) begin
                    fb_cnt <= fb_cnt + 1'b1;
                end
                fb_hit <= (fb_cnt >= HIT_V);
            end
        end
    end

    // R8: a clear seen by the feedback side empties the counter and the flag
    assert_fb_cleared_R8: assert property (
        @(posedge fb_clk) disable iff (!rst_n)
        clr_s |=> (fb_cnt == '0 && !fb_hit)
    );
endmodule

// File: rtl/race_ref_ctrl.sv
module race_ref_ctrl
    import freq_race_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int HIT_AT      = 230,
    parameter int RESTART_AT  = 240,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic ack_s,
    input  logic fb_hit_s,
    output logic clr_req,
    output logic fb_won,
    output logic race_done
);
    localparam int               AL_W      = $clog2(SYNC_STAGES + 1);
    localparam logic [CNT_W-1:0] HIT_V     = CNT_W'(HIT_AT);
    localparam logic [CNT_W-1:0] RESTART_V = CNT_W'(RESTART_AT);
    localparam logic [AL_W-1:0]  AL_LAST   = AL_W'(SYNC_STAGES - 1);

    // R9: the restart margin must cover the crossing latency
    if (RESTART_AT < HIT_AT + SYNC_STAGES + 2) begin : g_bad_margin
        $error("restart threshold too close to hit threshold");
    end

    race_state_t      state_q, state_d;
    logic [CNT_W-1:0] ref_cnt;
    logic [AL_W-1:0]  align_cnt;
    logic             ref_hit_raw;
    logic             ref_hit_d;
    logic             xor_q;
    logic             decided;
    logic             win_q;
    logic             race_xor;
    logic             restart_now;

    // Reference hit delayed by the same depth as the feedback crossing
    race_sync #(.STAGES(SYNC_STAGES)) u_ref_delay (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (ref_hit_raw),
        .q     (ref_hit_d)
    );

    assign race_xor    = ref_hit_d ^ fb_hit_s;
    assign restart_now = (ref_cnt > RESTART_V) && !ack_s;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (ack_s)                 state_d = ST_ALIGN;
            ST_ALIGN: if (align_cnt == AL_LAST)  state_d = ST_RACE;
            ST_RACE:  if (restart_now)           state_d = ST_CLEAR;
            default:                             state_d = ST_CLEAR;
        endcase
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_cnt     <= '0;
            align_cnt   <= '0;
            ref_hit_raw <= 1'b0;
            xor_q       <= 1'b0;
            decided     <= 1'b0;
            win_q       <= 1'b0;
            clr_req     <= 1'b1;
            fb_won      <= 1'b0;
            race_done   <= 1'b0;
        end else begin
            race_done <= 1'b0;
            unique case (state_q)
                ST_CLEAR: begin
                    ref_cnt     <= '0;
                    align_cnt   <= '0;
                    ref_hit_raw <= 1'b0;
                    xor_q       <= 1'b0;
                    decided     <= 1'b0;
                    win_q       <= 1'b0;
                    if (ack_s) begin
                        clr_req <= 1'b0;
                    end
                end
                ST_ALIGN: begin
                    align_cnt <= align_cnt + 1'b1;
                end
                ST_RACE: begin
                    if (ref_cnt != '1) begin
                        ref_cnt <= ref_cnt + 1'b1;
                    end
                    ref_hit_raw <= (ref_cnt >= HIT_V);
                    xor_q       <= race_xor;
                    if (race_xor && !xor_q && !decided) begin
                        decided <= 1'b1;
                        win_q   <= fb_hit_s;
                    end
                    if (restart_now) begin
                        fb_won    <= win_q;
                        race_done <= 1'b1;
                        clr_req   <= 1'b1;
                    end
                end
                default: begin
                    clr_req <= 1'b1;
                end
            endcase
        end
    end

    // R6: the strobe lasts one cycle
    assert_done_single_R6: assert property (
        @(posedge ref_clk) disable iff (!rst_n)
        race_done |=> !race_done
    );

    // R6: the result only moves together with the strobe
    assert_won_held_R6: assert property (
        @(posedge ref_clk) disable iff (!rst_n)
        !$stable(fb_won) |-> race_done
    );

    // R8: no release of the clear before the acknowledge
    assert_clr_held_R8: assert property (
        @(posedge ref_clk) disable iff (!rst_n)
        (state_q == ST_CLEAR && !ack_s) |=> clr_req
    );

    // R3: a lone feedback hit is recorded as a feedback win
    assert_fb_first_R3: assert property (
        @(posedge ref_clk) disable iff (!rst_n)
        (state_q == ST_RACE && !decided && fb_hit_s && !ref_hit_d) |=> (decided && win_q)
    );

    // R4, R5: a reference hit, alone or tied, is recorded as a reference win
    assert_ref_first_R4: assert property (
        @(posedge ref_clk) disable iff (!rst_n)
        (state_q == ST_RACE && !decided && ref_hit_d) |=> !win_q
    );
endmodule

// File: rtl/freq_race_cmp.sv
module freq_race_cmp #(
    parameter int CNT_W       = 10,
    parameter int HIT_AT      = 230,
    parameter int RESTART_AT  = 240,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic fb_clk,
    input  logic rst_n,
    output logic fb_won,
    output logic race_done
);
    logic clr_req;
    logic clr_s;
    logic fb_hit;
    logic fb_ack;
    logic fb_hit_s;
    logic ack_s;

    race_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
        .clk   (fb_clk),
        .rst_n (rst_n),
        .d     (clr_req),
        .q     (clr_s)
    );

    race_fb_side #(.CNT_W(CNT_W), .HIT_AT(HIT_AT)) u_fb_side (
        .fb_clk (fb_clk),
        .rst_n  (rst_n),
        .clr_s  (clr_s),
        .fb_hit (fb_hit),
        .fb_ack (fb_ack)
    );

    race_sync #(.STAGES(SYNC_STAGES)) u_hit_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (fb_hit),
        .q     (fb_hit_s)
    );

    race_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (fb_ack),
        .q     (ack_s)
    );

    race_ref_ctrl #(
        .CNT_W       (CNT_W),
        .HIT_AT      (HIT_AT),
        .RESTART_AT  (RESTART_AT),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_ref_ctrl (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .ack_s     (ack_s),
        .fb_hit_s  (fb_hit_s),
        .clr_req   (clr_req),
        .fb_won    (fb_won),
        .race_done (race_done)
    );
endmodule

// File: tb/freq_race_cmp_tb_top.sv
`timescale 1ns/1ps
module freq_race_cmp_tb_top;
    localparam int HIT_T  = 64;
    localparam int RST_T  = 80;
    localparam int SYNC_T = 2;
    localparam int PERIOD_T = 3 * SYNC_T + RST_T + 4;

    logic clk = 1'b0;
    logic fb_gen = 1'b0;
    logic tie_mode = 1'b0;
    logic rst_n = 1'b0;
    logic fb_clk;
    logic fb_won;
    logic race_done;
    real  fb_half = 4.0;
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;

    always #5 clk = ~clk;
    always #(fb_half) fb_gen = ~fb_gen;
    always @(posedge clk) cyc <= cyc + 1;
    assign fb_clk = tie_mode ? clk : fb_gen;

    freq_race_cmp #(
        .CNT_W(10), .HIT_AT(HIT_T), .RESTART_AT(RST_T), .SYNC_STAGES(SYNC_T)
    ) dut_i (
        .ref_clk(clk), .fb_clk(fb_clk), .rst_n(rst_n),
        .fb_won(fb_won), .race_done(race_done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_case(input real per, input bit tie, input bit exp_won);
        int last_cyc = 0;
        rst_n = 1'b0;
        tie_mode = tie;
        fb_half = per / 2.0;
        repeat (4) @(negedge clk);
        check("R1 reset done", int'(race_done), 0);
        check("R1 reset won", int'(fb_won), 0);
        rst_n = 1'b1;
        for (int q = 0; q < 40; q++) begin
            @(negedge clk);
            if (race_done) check("R1 early pulse", 1, 0);
        end
        for (int k = 0; k < 3; k++) begin
            int n = 0;
            while (!race_done && n < 2000) begin
                @(negedge clk);
                n++;
            end
            check("R6 pulse seen", int'(race_done), 1);
            // R3 / R4 / R5: winner valid with the strobe
            check(tie ? "R5 tie result" : (exp_won ? "R3 fb faster" : "R4 ref faster"),
                  int'(fb_won), int'(exp_won));
            if (tie && k > 0) check("R7 race period", cyc - last_cyc, PERIOD_T);
            last_cyc = cyc;
            @(negedge clk);
            check("R6 pulse width", int'(race_done), 0);
            check("R6 result held", int'(fb_won), int'(exp_won));
        end
    endtask

    initial begin
        // R2: identical clocks start together and tie
        run_case(10.0, 1'b1, 1'b0);
        for (int p = 4; p <= 8; p++) run_case(real'(p), 1'b0, 1'b1);
        for (int p = 12; p <= 20; p += 2) run_case(real'(p), 1'b0, 1'b0);
        run_case(10.0, 1'b1, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule